// File: doc/BRIEF.md
# Closed Caption Byte Pair Capture

This block sits behind a line-21 caption bit slicer on a 525-line video path. Each time the slicer finishes a caption line it raises a single-cycle pulse carrying the sixteen decoded bits (two 8-bit characters, each with its own parity bit) and a flag saying whether the line came from field 1 or from field 2, the extended-data field. The block checks odd parity on each character. It keeps the latest pair per field in its own pair of byte registers, with the 7-bit character in the low bits and the parity verdict in bit 7.

Per field the block keeps two flags. The valid flag says that the field is carrying good caption data in the current frame. The ready flag says that a fresh pair has arrived that software has not yet fetched. A polling reader checks the status register, fetches the two bytes, and the ready flag drops once the second byte has been read. A frame marker input ages the valid flags.

Top module: `captionCapture`

## Requirements
- R1: A capture pulse writes its low byte into the first and its high byte into the second data register of the field given by the field input (0 = field 1, 1 = field 2). The other field's registers are left unchanged.
- R2: Each stored byte holds the character's bits 6..0 unchanged. Its bit 7 is 1 exactly when the incoming 8 bits have an odd number of ones, and 0 otherwise.
- R3: Register map at the default base 0x1A: 0x1A field 1 first byte, 0x1B field 1 second byte, 0x1C status, 0x1D field 2 first byte, 0x1E field 2 second byte.
- R4: Status byte: bit 0 field 1 valid, bit 1 field 2 valid, bit 2 field 1 ready, bit 3 field 2 ready, bits 7..4 zero. A field's valid flag sets on a capture for that field in which both bytes pass parity. A capture with a parity failure does not set it.
- R5: Any capture for a field sets that field's ready flag on the following cycle.
- R6: A read of a field's second byte register clears that field's ready flag. A read of its first byte, of the status register or of the other field's registers does not.
- R7: When a capture and a clearing read of the same field fall in the same cycle, the ready flag stays set, and the read returns the bytes held before the capture.
- R8: At a frame marker, a field's valid flag becomes 1 only if a parity-clean capture for that field arrived since the previous marker, counting one in the marker's own cycle. Otherwise it becomes 0.
- R9: Read data appears on the cycle after the read strobe. It is 0 in every cycle not following a strobe, and for strobes to addresses outside the map.
- R10: After reset every data register, flag and the read output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capValid | input | 1 | One-cycle pulse: a decoded caption pair is present |
| capField | input | 1 | Field of the pair, 0 = field 1, 1 = field 2 |
| capBits | input | 16 | Decoded bits, low byte first character, high byte second |
| frameMark | input | 1 | One-cycle pulse at each frame boundary |
| rdStrobe | input | 1 | Register read request |
| rdAddr | input | 8 | Register address for the read |
| rdData | output | 8 | Read data, valid the cycle after the strobe |

## Verification
A wrong ready flag shows in the status byte on the first read after the offending capture or clearing read, one cycle after the strobe. A stale or misrouted data byte shows on the next read of that field's registers. A wrong parity bit is visible in bit 7 of the byte read back. A valid flag that ages wrongly shows up only after a frame marker, so the status is read after each marker, including one that coincides with a capture.

// File: rtl/captionPkg.sv
package captionPkg;
  localparam int BYTE_W = 8;
  localparam int N_FIELDS = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_F1A,
    SEL_F1B,
    SEL_STAT,
    SEL_F2A,
    SEL_F2B
  } regSel_e;

  typedef struct packed {
    logic [N_FIELDS-1:0] capWr;
    logic                rdEn;
    regSel_e             rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/captionCtrl.sv
module captionCtrl
  import captionPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                capValid,
  input  logic                capField,
  input  logic [2*BYTE_W-1:0] capBits,
  input  logic                frameMark,
  input  logic                rdStrobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  output ctrlStrobes_t        strobes,
  output logic [N_FIELDS-1:0] fieldVal,
  output logic [N_FIELDS-1:0] fieldRdy
);
  logic [ADDR_W-1:0]   offset;
  regSel_e             sel;
  logic [N_FIELDS-1:0] capHit;
  logic [N_FIELDS-1:0] cleanHit;
  logic [N_FIELDS-1:0] clrHit;
  logic [N_FIELDS-1:0] seenClean;
  logic                pairClean;

  assign offset    = rdAddr - BASE_ADDR;
  assign pairClean = (^capBits[BYTE_W-1:0]) & (^capBits[2*BYTE_W-1:BYTE_W]);

  always_comb begin
    case (offset)
      ADDR_W'(0): sel = SEL_F1A;
      ADDR_W'(1): sel = SEL_F1B;
      ADDR_W'(2): sel = SEL_STAT;
      ADDR_W'(3): sel = SEL_F2A;
      ADDR_W'(4): sel = SEL_F2B;
      default:    sel = SEL_NONE;
    endcase
  end

  assign strobes.capWr = capHit;
  assign strobes.rdEn  = rdStrobe;
  assign strobes.rdSel = sel;

  genvar f;
  generate
    for (f = 0; f < N_FIELDS; f++) begin : g_field
      localparam regSel_e SECOND = (f == 0) ? SEL_F1B : SEL_F2B;
      assign capHit[f]   = capValid && (capField == f[0]);
      assign cleanHit[f] = capHit[f] && pairClean;
      assign clrHit[f]   = rdStrobe && (sel == SECOND);

      // ready: a new capture beats a clearing read in the same cycle
      always_ff @(posedge clk) begin
        if (!rstN)            fieldRdy[f] <= 1'b0;
        else if (capHit[f])   fieldRdy[f] <= 1'b1;
        else if (clrHit[f])   fieldRdy[f] <= 1'b0;
      end

      // valid: re-evaluated at each frame marker from what was seen
      always_ff @(posedge clk) begin
        if (!rstN) begin
          fieldVal[f]  <= 1'b0;
          seenClean[f] <= 1'b0;
        end else if (frameMark) begin
          fieldVal[f]  <= seenClean[f] | cleanHit[f];
          seenClean[f] <= cleanHit[f];
        end else if (cleanHit[f]) begin
          fieldVal[f]  <= 1'b1;
          seenClean[f] <= 1'b1;
        end
      end

      a_r5_ready_sets: assert property (@(posedge clk) disable iff (!rstN)
        capHit[f] |=> fieldRdy[f]);
      a_r6_ready_clears: assert property (@(posedge clk) disable iff (!rstN)
        (clrHit[f] && !capHit[f]) |=> !fieldRdy[f]);
      a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
        (clrHit[f] && capHit[f]) |=> fieldRdy[f]);
      a_r4_valid_source: assert property (@(posedge clk) disable iff (!rstN)
        $rose(fieldVal[f]) |-> $past(cleanHit[f]));
    end
  endgenerate
endmodule

// File: rtl/captionData.sv
module captionData
  import captionPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*BYTE_W-1:0] capBits,
  input  ctrlStrobes_t        strobes,
  input  logic [N_FIELDS-1:0] fieldVal,
  input  logic [N_FIELDS-1:0] fieldRdy,
  output logic [BYTE_W-1:0]   rdData
);
  logic [BYTE_W-1:0] byteA [N_FIELDS];
  logic [BYTE_W-1:0] byteB [N_FIELDS];
  logic [BYTE_W-1:0] tagA, tagB, statusByte;

  // bit 7 carries the parity verdict, low bits the character
  assign tagA = {^capBits[BYTE_W-1:0], capBits[BYTE_W-2:0]};
  assign tagB = {^capBits[2*BYTE_W-1:BYTE_W], capBits[2*BYTE_W-2:BYTE_W]};
  assign statusByte = {{(BYTE_W-2*N_FIELDS){1'b0}}, fieldRdy, fieldVal};

  genvar f;
  generate
    for (f = 0; f < N_FIELDS; f++) begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN) begin
          byteA[f] <= '0;
          byteB[f] <= '0;
        end else if (strobes.capWr[f]) begin
          byteA[f] <= tagA;
          byteB[f] <= tagB;
        end
      end

      a_r2_parity_msb: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capWr[f] |=> (byteA[f][BYTE_W-1] == ^$past(capBits[BYTE_W-1:0])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.rdEn) rdData <= '0;
    else begin
      case (strobes.rdSel)
        SEL_F1A:  rdData <= byteA[0];
        SEL_F1B:  rdData <= byteB[0];
        SEL_STAT: rdData <= statusByte;
        SEL_F2A:  rdData <= byteA[1];
        SEL_F2B:  rdData <= byteB[1];
        default:  rdData <= '0;
      endcase
    end
  end

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> (rdData == '0));
endmodule

// File: rtl/captionCapture.sv
module captionCapture
  import captionPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                capValid,
  input  logic                capField,
  input  logic [2*BYTE_W-1:0] capBits,
  input  logic                frameMark,
  input  logic                rdStrobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [BYTE_W-1:0]   rdData
);
  ctrlStrobes_t        strobes;
  logic [N_FIELDS-1:0] fieldVal;
  logic [N_FIELDS-1:0] fieldRdy;

  captionCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capField(capField),
    .capBits(capBits), .frameMark(frameMark), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .strobes(strobes), .fieldVal(fieldVal), .fieldRdy(fieldRdy)
  );

  captionData u_data (
    .clk(clk), .rstN(rstN), .capBits(capBits), .strobes(strobes),
    .fieldVal(fieldVal), .fieldRdy(fieldRdy), .rdData(rdData)
  );

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (rdData == '0));
endmodule

// File: tb/captionCapture_bench.sv
`timescale 1ns/1ps
module captionCapture_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capValid = 1'b0, capField = 1'b0, frameMark = 1'b0, rdStrobe = 1'b0;
  logic [15:0] capBits = '0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  rdData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  captionCapture u_captionCapture (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capField(capField),
    .capBits(capBits), .frameMark(frameMark), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [7:0] stored(input logic [7:0] b);
    return {^b, b[6:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic capture(input logic fld, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    capValid = 1'b1; capField = fld; capBits = {b1, b0};
    @(negedge clk);
    capValid = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdStrobe = 1'b1; rdAddr = a;
    @(negedge clk);
    rdStrobe = 1'b0;
    d = rdData;
  endtask

  task automatic frame();
    @(negedge clk);
    frameMark = 1'b1;
    @(negedge clk);
    frameMark = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R10 idle out", rdData, 8'h00);
    for (int a = 8'h1A; a <= 8'h1E; a++) begin
      readReg(8'(a), d);
      chk("R10 reg after reset", d, 8'h00);
    end
  endtask

  task automatic testField1Clean();
    logic [7:0] d;
    capture(1'b0, 8'hC1, 8'h52);
    readReg(8'h1A, d); chk("R1 R2 f1 first byte", d, stored(8'hC1));
    readReg(8'h1C, d); chk("R4 R5 status f1", d, 8'h05);
    readReg(8'h1D, d); chk("R1 f2 untouched", d, 8'h00);
    @(negedge clk);    chk("R9 no strobe zero", rdData, 8'h00);
  endtask

  task automatic testField2Bad();
    logic [7:0] d;
    capture(1'b1, 8'h41, 8'h43);
    readReg(8'h1D, d); chk("R2 f2 first parity fail", d, 8'h41);
    readReg(8'h1E, d); chk("R2 R3 f2 second byte", d, stored(8'h43));
    readReg(8'h1C, d); chk("R6 status after f2 second read", d, 8'h05);
  endtask

  task automatic testReadyClear();
    logic [7:0] d;
    capture(1'b1, 8'h41, 8'h43);
    readReg(8'h1C, d); chk("R4 R5 f2 ready no valid", d, 8'h0D);
    readReg(8'h1A, d); chk("R1 f1 first reread", d, 8'hC1);
    readReg(8'h1C, d); chk("R6 first byte keeps ready", d, 8'h0D);
    readReg(8'h1B, d); chk("R2 f1 second byte", d, stored(8'h52));
    readReg(8'h1C, d); chk("R6 f1 ready cleared", d, 8'h09);
  endtask

  task automatic testCollision();
    logic [7:0] d;
    @(negedge clk);
    capValid = 1'b1; capField = 1'b0; capBits = {8'hA8, 8'h62};
    rdStrobe = 1'b1; rdAddr = 8'h1B;
    @(negedge clk);
    capValid = 1'b0; rdStrobe = 1'b0;
    chk("R7 read returns old byte", rdData, stored(8'h52));
    readReg(8'h1C, d); chk("R7 ready kept", d, 8'h0D);
    readReg(8'h1A, d); chk("R1 new f1 byte", d, stored(8'h62));
  endtask

  task automatic testFrameAging();
    logic [7:0] d;
    frame();
    readReg(8'h1C, d); chk("R8 f1 valid kept one marker", d & 8'h03, 8'h01);
    frame();
    readReg(8'h1C, d); chk("R8 f1 valid aged out", d & 8'h03, 8'h00);
    @(negedge clk);
    frameMark = 1'b1; capValid = 1'b1; capField = 1'b1; capBits = {8'h01, 8'h07};
    @(negedge clk);
    frameMark = 1'b0; capValid = 1'b0;
    frame();
    readReg(8'h1C, d); chk("R8 capture at marker counts", d & 8'h03, 8'h02);
    frame();
    readReg(8'h1C, d); chk("R8 f2 valid aged out", d & 8'h03, 8'h00);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    readReg(8'h19, d); chk("R9 below map", d, 8'h00);
    readReg(8'h1F, d); chk("R9 above map", d, 8'h00);
    readReg(8'h1E, d); chk("R3 f2 second byte", d, stored(8'h01));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testField1Clean();
    testField2Bad();
    testReadyClear();
    testCollision();
    testFrameAging();
    testUnmapped();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule